// File: doc/BRIEF.md
# Hexadecimal Keypad Skip and Wait Unit

This block serves the keypad instructions of a small 8-bit virtual processor that reads a sixteen-key hexadecimal pad. Each cycle it receives the raw up/down state of all keys, a two-bit command and the value of the register the instruction names. From these it returns three things. The first is a request to advance the program counter by one instruction when a conditional skip is taken. The second is a pause flag that holds the processor while it waits for a key. The third is a register write strobe carrying the index of the key that ended the wait.

The two skip commands look at one key, chosen by the low nibble of the register value, and decide in the same cycle. The wait command is a three-phase exchange. Its first issue pauses the processor. Pressing and holding a key keeps the processor paused. Letting a key go lifts the pause and latches that key. The processor then issues the wait again, and that second issue writes the latched index into the register. Alongside this, the block reports one-cycle press and release pulses for every key, found by comparing each sample with the sample of the cycle before.

Top module: `hexpad_ctrl`

## Requirements
- R1: With command 2'b01 (skip when down), `pc_inc_o` is 1 in the same cycle exactly when `keys_i[vx_i[3:0]]` is 1, and 0 otherwise.
- R2: With command 2'b10 (skip when up), `pc_inc_o` is 1 in the same cycle exactly when `keys_i[vx_i[3:0]]` is 0, and 0 otherwise.
- R3: A skip decision depends only on the selected key: other keys and the upper bits of `vx_i` do not change it. With command 2'b00 (none) or 2'b11 (wait), `pc_inc_o` is 0.
- R4: Command 2'b11 issued while idle raises `pause_o` on the next cycle, does not assert `vx_we_o`, and clears any previously latched key to 0.
- R5: While `pause_o` is 1, pressing or holding keys, or issuing command 2'b11 again, keeps `pause_o` at 1 and `vx_we_o` at 0, for as long as no key is released.
- R6: While `pause_o` is 1, a cycle in which at least one key goes from down to up clears `pause_o` on the next cycle and latches that key's index. If several keys are released in the same cycle, the lowest index is latched. Releases while not paused latch nothing.
- R7: `press_o[k]` is 1 for one cycle when `keys_i[k]` is 1 and was 0 in the previous cycle's sample, and `release_o[k]` is 1 in the opposite case. A key that stays down or stays up gives no pulse. The sample taken at reset is all keys up.
- R8: After a completed wait, the next command 2'b11 asserts `vx_we_o` in that same cycle with `vx_wdata_o` equal to the latched index, zero-extended. The unit then returns to idle, so a further 2'b11 starts a new wait.
- R9: During reset and in the first cycle after it, `pause_o` and `vx_we_o` are 0 and `vx_wdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| keys_i | input | 16 | Key state, 1 = down, bit k = key k |
| op_i | input | 2 | Command: 00 none, 01 skip when down, 10 skip when up, 11 wait |
| vx_i | input | 8 | Value of the register named by the instruction |
| pc_inc_o | output | 1 | Request to advance the program counter past the next instruction |
| pause_o | output | 1 | Processor stall while waiting for a key |
| vx_we_o | output | 1 | Register write strobe ending a wait |
| vx_wdata_o | output | 8 | Key index to write, zero-extended |
| press_o | output | 16 | One-cycle press pulses per key |
| release_o | output | 16 | One-cycle release pulses per key |

## Verification
The bench targets selection by the low nibble when the register's upper bits are set and the other fifteen keys hold the opposite level. A design that decoded the full byte, or looked at a neighbouring key, would give the wrong skip there. It drives two keys released in the same cycle while waiting, which catches a unit that latches the highest index. It also drives a release that happens before any wait, which a unit that records releases while idle would wrongly turn into a completion. A long stretch of held keys and repeated wait commands shows whether the pause ever drops on a press instead of a release, and whether the write strobe fires a cycle early or more than once.

// File: rtl/hexpad_pkg.sv
package hexpad_pkg;

  // Command encoding on op_i (decoded by the skip and wait logic)
  typedef enum logic [1:0] {
    OP_NONE      = 2'b00,
    OP_SKIP_DOWN = 2'b01,
    OP_SKIP_UP   = 2'b10,
    OP_WAIT      = 2'b11
  } pad_op_e;

  // Phases of the wait exchange
  typedef enum logic [1:0] {
    WS_IDLE  = 2'b00,
    WS_ARMED = 2'b01,
    WS_READY = 2'b10
  } wait_state_e;

endpackage

// File: rtl/hexpad_edge.sv
module hexpad_edge #(
  parameter int NUM_KEYS = 16,
  parameter int IDX_W    = $clog2(NUM_KEYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] keys_i,
  output logic [NUM_KEYS-1:0] press_o,
  output logic [NUM_KEYS-1:0] release_o,
  output logic                rel_any_o,
  output logic [IDX_W-1:0]    rel_idx_o
);

  logic [NUM_KEYS-1:0] keys_q;

  // Lowest set bit wins: scan downward so the last hit is the smallest index.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_KEYS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // Previous sample; reset means every key up.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) keys_q <= '0;
    else         keys_q <= keys_i;
  end

  assign press_o   = keys_i & ~keys_q;
  assign release_o = ~keys_i & keys_q;
  assign rel_any_o = |release_o;
  assign rel_idx_o = lowest_set(release_o);

  // R7: a press pulse on a key cannot repeat in the following cycle
  p_press_single_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_o != '0) |=> ((press_o & $past(press_o)) == '0));

  // R7: same for release pulses
  p_release_single_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o != '0) |=> ((release_o & $past(release_o)) == '0));

  // R6: the reported index points at a key that really was released
  p_rel_idx_valid_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_any_o |-> release_o[rel_idx_o]);

endmodule

// File: rtl/hexpad_skip.sv
module hexpad_skip
  import hexpad_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  parameter int IDX_W    = $clog2(NUM_KEYS)
) (
  input  logic [NUM_KEYS-1:0] keys_i,
  input  pad_op_e             op_i,
  input  logic [IDX_W-1:0]    sel_i,
  output logic                pc_inc_o
);

  logic key_down;

  assign key_down = keys_i[sel_i];

  always_comb begin
    unique case (op_i)
      OP_SKIP_DOWN: pc_inc_o = key_down;
      OP_SKIP_UP:   pc_inc_o = ~key_down;
      default:      pc_inc_o = 1'b0;
    endcase
  end

  // R3: a skip request only ever comes from one of the two skip commands
  always_comb begin
    p_skip_from_op_r3 : assert (!pc_inc_o || op_i == OP_SKIP_DOWN || op_i == OP_SKIP_UP);
  end

endmodule

// File: rtl/hexpad_wait.sv
module hexpad_wait
  import hexpad_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pad_op_e          op_i,
  input  logic             rel_any_i,
  input  logic [IDX_W-1:0] rel_idx_i,
  output logic             pause_o,
  output logic             we_o,
  output logic [IDX_W-1:0] key_o
);

  wait_state_e      state_q, state_d;
  logic [IDX_W-1:0] last_q, last_d;

  always_comb begin
    state_d = state_q;
    last_d  = last_q;
    unique case (state_q)
      WS_IDLE: begin
        if (op_i == OP_WAIT) begin
          state_d = WS_ARMED;
          last_d  = '0;          // drop any stale key from an earlier wait
        end
      end
      WS_ARMED: begin
        if (rel_any_i) begin
          state_d = WS_READY;
          last_d  = rel_idx_i;
        end
      end
      WS_READY: begin
        if (op_i == OP_WAIT) state_d = WS_IDLE;
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      last_q  <= last_d;
    end
  end

  assign pause_o = (state_q == WS_ARMED);
  assign we_o    = (state_q == WS_READY) && (op_i == OP_WAIT);
  assign key_o   = last_q;

  // R4: a wait issued while neither paused nor completing arms the pause
  p_arm_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WAIT && !pause_o && !we_o) |=> pause_o);

  // R5: no release means the pause holds
  p_pause_hold_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_o && !rel_any_i) |=> pause_o);

  // R5: never a register write while paused
  p_no_write_paused_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_o |-> !we_o);

  // R6: a release while paused lifts the pause
  p_resume_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_o && rel_any_i) |=> !pause_o);

  // R8: the write strobe is a single pulse, followed by idle
  p_single_write_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (!we_o && !pause_o));

endmodule

// File: rtl/hexpad_ctrl.sv
module hexpad_ctrl
  import hexpad_pkg::*;
#(
  parameter int NUM_KEYS = 16,
  parameter int REG_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_KEYS-1:0] keys_i,
  input  logic [1:0]          op_i,
  input  logic [REG_W-1:0]    vx_i,
  output logic                pc_inc_o,
  output logic                pause_o,
  output logic                vx_we_o,
  output logic [REG_W-1:0]    vx_wdata_o,
  output logic [NUM_KEYS-1:0] press_o,
  output logic [NUM_KEYS-1:0] release_o
);

  localparam int IDX_W = $clog2(NUM_KEYS);

  pad_op_e          op;
  logic             rel_any;
  logic [IDX_W-1:0] rel_idx;
  logic [IDX_W-1:0] key_idx;

  assign op = pad_op_e'(op_i);

  hexpad_edge #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .keys_i    (keys_i),
    .press_o   (press_o),
    .release_o (release_o),
    .rel_any_o (rel_any),
    .rel_idx_o (rel_idx)
  );

  hexpad_skip #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) i_skip (
    .keys_i   (keys_i),
    .op_i     (op),
    .sel_i    (vx_i[IDX_W-1:0]),
    .pc_inc_o (pc_inc_o)
  );

  hexpad_wait #(.IDX_W(IDX_W)) i_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .rel_any_i (rel_any),
    .rel_idx_i (rel_idx),
    .pause_o   (pause_o),
    .we_o      (vx_we_o),
    .key_o     (key_idx)
  );

  assign vx_wdata_o = {{(REG_W - IDX_W){1'b0}}, key_idx};

endmodule

// File: tb/test_hexpad_ctrl.sv
module test_hexpad_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] keys = '0;
  logic [1:0]  op = 2'b00;
  logic [7:0]  vx = '0;
  logic        pc_inc, pause, we;
  logic [7:0]  wdata;
  logic [15:0] press, rel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  hexpad_ctrl i_hexpad_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .keys_i(keys), .op_i(op), .vx_i(vx),
    .pc_inc_o(pc_inc), .pause_o(pause), .vx_we_o(we), .vx_wdata_o(wdata),
    .press_o(press), .release_o(rel)
  );

  // Behavioural reference: 0 idle, 1 waiting, 2 key captured
  logic [15:0] m_prev = '0;
  int          m_state = 0;
  int          m_last  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = '0; m_state = 0; m_last = 0;
    end else begin
      int lo;
      lo = -1;
      for (int k = 15; k >= 0; k--) if (!keys[k] && m_prev[k]) lo = k;
      case (m_state)
        0: if (op == 2'b11) begin m_state = 1; m_last = 0; end
        1: if (lo >= 0) begin m_state = 2; m_last = lo; end
        default: if (op == 2'b11) m_state = 0;
      endcase
      m_prev = keys;
    end
  end

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R9 pause in reset", pause, 0);
      chk("R9 write in reset", we, 0);
    end else begin
      logic sel;
      logic exp_skip;
      string ptag;
      sel = keys[vx % 16];
      exp_skip = (op == 2'b01) ? sel : (op == 2'b10) ? !sel : 1'b0;
      if (op == 2'b01)      chk("R1 skip when down", pc_inc, exp_skip);
      else if (op == 2'b10) chk("R2 skip when up", pc_inc, exp_skip);
      else                  chk("R3 no skip on other command", pc_inc, 0);
      chk("R7 press pulses", press, keys & ~m_prev);
      chk("R7 release pulses", rel, ~keys & m_prev);
      ptag = (m_state == 0) ? "R4 pause" : (m_state == 1) ? "R5 pause" : "R6 pause";
      chk(ptag, pause, m_state == 1);
      chk("R8 write strobe", we, (m_state == 2) && (op == 2'b11));
      chk("R8 write data", wdata, m_last);
    end
  end

  task automatic drive(input logic [1:0] o, input logic [15:0] k, input logic [7:0] v);
    @(posedge clk); #1;
    op = o; keys = k; vx = v;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 pause after reset", pause, 0);
    chk("R9 data after reset", wdata, 0);

    // Skip: walking single key, and all keys but one, upper nibble of vx set
    for (int k = 0; k < 16; k++) begin
      drive(2'b01, 16'h1 << k, 8'hA0 | 8'(k));
      drive(2'b10, 16'h1 << k, 8'h50 | 8'(k));
      drive(2'b01, ~(16'h1 << k), 8'hF0 | 8'(k));       // R3 others down
      drive(2'b10, ~(16'h1 << k), 8'h30 | 8'((k + 1) % 16));
    end
    drive(2'b00, 16'hFFFF, 8'h00);
    drive(2'b00, 16'h0000, 8'h00);

    // Release before any wait must not complete a later wait (R6)
    drive(2'b00, 16'h0040, 8'h00);
    drive(2'b00, 16'h0000, 8'h00);
    drive(2'b11, 16'h0000, 8'h00);
    drive(2'b00, 16'h0000, 8'h00);
    @(negedge clk); chk("R4 armed by wait", pause, 1);
    // Press, hold, and re-issued waits keep it paused (R5)
    drive(2'b11, 16'h0020, 8'h00);
    drive(2'b11, 16'h0020, 8'h00);
    drive(2'b00, 16'h0020, 8'h00);
    @(negedge clk); chk("R5 held key keeps pause", pause, 1);
    drive(2'b00, 16'h0000, 8'h00);                      // release key 5
    drive(2'b00, 16'h0000, 8'h00);
    @(negedge clk); chk("R6 release lifts pause", pause, 0);
    drive(2'b11, 16'h0000, 8'h00);
    @(negedge clk); chk("R8 write strobe", we, 1); chk("R8 key index 5", wdata, 5);
    drive(2'b00, 16'h0000, 8'h00);

    // Two keys released together: lowest index wins (R6)
    drive(2'b11, 16'h0208, 8'h00);
    drive(2'b00, 16'h0208, 8'h00);
    drive(2'b00, 16'h0000, 8'h00);
    drive(2'b11, 16'h0000, 8'h00);
    @(negedge clk); chk("R6 lowest released key", wdata, 3);
    drive(2'b00, 16'h0000, 8'h00);

    // Mixed pseudo-random traffic, checked against the model every cycle
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[3:2], keys ^ (16'h1 << lfsr[7:4]) ^ (lfsr[8] ? (16'h1 << lfsr[12:9]) : 16'h0),
            lfsr[23:16]);
    end
    drive(2'b00, 16'h0000, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
    end
  end

endmodule